// File: doc/BRIEF.md
# IN Endpoint Transmit Buffer with Retry

This block holds the outgoing packet for one non-isochronous IN endpoint of a full-speed USB device. Firmware fills the buffer a byte at a time through a valid/ready write stream, up to a size it chooses at run time (1 to 64 bytes). It then arms the endpoint. When the packet engine reports an IN token, the buffer streams the packet out through a second valid/ready interface. The engine then reports either an ACK from the host or a handshake timeout.

An ACK empties the buffer, disarms the endpoint and pulses the endpoint interrupt. A timeout leaves the packet and the armed state untouched, and it raises no interrupt. The next IN token then replays the packet from its first byte. Tokens that arrive with a reception error have no effect. A token that arrives while the endpoint is not armed asks the engine to answer NAK. If firmware clears the buffer while bytes are going out, the block tells the engine to corrupt the packet with a bit-stuff violation. The request holds until the engine reports how the transaction ended.

Both streams follow the usual back-pressure rule: a byte moves only on a cycle where valid and ready are both high. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values. On the write side, `wr_ready` is low whenever a write would be refused, so a held `wr_valid` simply waits.

Top module: `usb_in_txbuf`

## Requirements
- R1: Out of reset, the block is idle and disarmed, with `byte_count` 0, `wr_ready` 1, and `tx_valid`, `nak_req`, `ep_irq` and `force_bs_err` all 0.
- R2: While idle and disarmed with `byte_count` below `cfg_size`, `wr_ready` is 1. Each accepted write stores its byte at position `byte_count` and increments the count by one.
- R3: Once `byte_count` equals `cfg_size`, `wr_ready` is 0 and further writes are refused without changing `byte_count`. Writes are also refused while the endpoint is armed.
- R4: A `cpu_arm` pulse while idle sets `ep_enabled` on the next clock edge.
- R5: An IN token with `tok_err` high is ignored: no data is offered, no NAK is requested, and neither `byte_count` nor `ep_enabled` changes.
- R6: A clean IN token while disarmed produces a one-cycle `nak_req` pulse in the following cycle, and no data.
- R7: A clean IN token while armed with a non-empty buffer starts the packet. From the next cycle, `tx_valid` offers the bytes in write order starting at byte 0. `tx_last` marks the final byte, and data holds stable while `tx_ready` is low.
- R8: An `ack_rx` strobe after the last byte empties the buffer and clears `ep_enabled`. It also raises `ep_irq` for exactly one cycle, in the cycle after the strobe.
- R9: An `hs_timeout` strobe after the last byte keeps `byte_count` and `ep_enabled` and raises no interrupt. The next clean token resends the packet from byte 0.
- R10: A `cpu_clear` while the packet is streaming empties and disarms the buffer and drops `tx_valid`. From the next cycle, `force_bs_err` stays high until `hs_timeout` or `ack_rx`, and that ending raises no interrupt.
- R11: A clean token while armed with an empty buffer sends a zero-length packet: no byte is offered, and the block waits for the handshake. A following ACK behaves as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size | input | 7 | Packet size limit in bytes, 1 to 64 |
| wr_valid | input | 1 | Firmware write byte present |
| wr_ready | output | 1 | Buffer accepts a write this cycle |
| wr_data | input | 8 | Firmware write byte |
| cpu_arm | input | 1 | Arm endpoint (pulse) |
| cpu_clear | input | 1 | Empty buffer and disarm (pulse) |
| tok_in | input | 1 | IN token received (strobe) |
| tok_err | input | 1 | Token had CRC, stuffing or PID error |
| tx_valid | output | 1 | Packet byte offered to engine |
| tx_ready | input | 1 | Engine takes the offered byte |
| tx_data | output | 8 | Packet byte |
| tx_last | output | 1 | Offered byte is the final one |
| ack_rx | input | 1 | Host ACK received (strobe) |
| hs_timeout | input | 1 | No handshake within time limit (strobe) |
| nak_req | output | 1 | Engine should answer NAK (pulse) |
| force_bs_err | output | 1 | Engine should corrupt the packet with a stuffing error |
| ep_irq | output | 1 | Endpoint transfer complete (pulse) |
| ep_enabled | output | 1 | Endpoint armed |
| byte_count | output | 7 | Bytes held in buffer |

## Verification
The properties assume that `ack_rx` and `hs_timeout` never fire in the same cycle, that `cfg_size` stays in 1..64 and changes only while the buffer is empty, and that the engine raises handshake strobes only after the packet has ended. The bench drives each strobe as a lone one-cycle pulse, changes `cfg_size` only after an ACK or clear, and sends a handshake only once `tx_valid` has dropped. A token flagged as errored is issued only while no packet is streaming. That keeps the "no effect" properties on states where the claim is meaningful.

// File: rtl/usb_in_txbuf_pkg.sv
package usb_in_txbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEND    = 2'd1,
    ST_WAIT_HS = 2'd2,
    ST_ABORT   = 2'd3
  } txb_state_e;
endpackage

// File: rtl/txbuf_mem.sv
module txbuf_mem #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
  import usb_in_txbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_size,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          cpu_arm,
  input  logic          cpu_clear,
  input  logic          tok_in,
  input  logic          tok_err,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last,
  input  logic          ack_rx,
  input  logic          hs_timeout,
  output logic          nak_req,
  output logic          force_bs_err,
  output logic          ep_irq,
  output logic          ep_enabled,
  output logic [CW-1:0] byte_count,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW-1:0] mem_raddr
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  txb_state_e    state;
  logic [CW-1:0] count_q;
  logic [CW-1:0] rd_ptr;
  logic          en_q;
  logic [CW-1:0] limit;
  logic          tok_ok;
  logic          take;

  assign limit     = (cfg_size > DEPTH_C) ? DEPTH_C : cfg_size;
  assign wr_ready  = (state == ST_IDLE) && !en_q && (count_q < limit);
  assign mem_we    = wr_valid && wr_ready && !cpu_clear;
  assign mem_waddr = count_q[AW-1:0];
  assign mem_raddr = rd_ptr[AW-1:0];

  assign tok_ok       = tok_in && !tok_err && (state == ST_IDLE);
  assign tx_valid     = (state == ST_SEND);
  assign tx_last      = tx_valid && (rd_ptr == count_q - CW'(1));
  assign take         = tx_valid && tx_ready;
  assign force_bs_err = (state == ST_ABORT);
  assign ep_enabled   = en_q;
  assign byte_count   = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      count_q <= '0;
      rd_ptr  <= '0;
      en_q    <= 1'b0;
      nak_req <= 1'b0;
      ep_irq  <= 1'b0;
    end else begin
      nak_req <= 1'b0;
      ep_irq  <= 1'b0;
      if (cpu_clear) begin
        count_q <= '0;
        rd_ptr  <= '0;
        en_q    <= 1'b0;
        if (state == ST_SEND) state <= ST_ABORT;
        else if (state == ST_WAIT_HS) state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (mem_we) count_q <= count_q + CW'(1);
            if (cpu_arm) en_q <= 1'b1;
            if (tok_ok) begin
              if (en_q) begin
                rd_ptr <= '0;
                state  <= (count_q == '0) ? ST_WAIT_HS : ST_SEND;
              end else begin
                nak_req <= 1'b1;
              end
            end
          end
          ST_SEND: begin
            if (take) begin
              rd_ptr <= rd_ptr + CW'(1);
              if (tx_last) state <= ST_WAIT_HS;
            end
          end
          ST_WAIT_HS: begin
            if (ack_rx) begin
              count_q <= '0;
              rd_ptr  <= '0;
              en_q    <= 1'b0;
              ep_irq  <= 1'b1;
              state   <= ST_IDLE;
            end else if (hs_timeout) begin
              rd_ptr <= '0;
              state  <= ST_IDLE;
            end
          end
          ST_ABORT: begin
            if (ack_rx || hs_timeout) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/usb_in_txbuf.sv
module usb_in_txbuf #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_size,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [7:0]    wr_data,
  input  logic          cpu_arm,
  input  logic          cpu_clear,
  input  logic          tok_in,
  input  logic          tok_err,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          ack_rx,
  input  logic          hs_timeout,
  output logic          nak_req,
  output logic          force_bs_err,
  output logic          ep_irq,
  output logic          ep_enabled,
  output logic [CW-1:0] byte_count
);
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [AW-1:0] mem_raddr;

  txbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .cpu_arm(cpu_arm), .cpu_clear(cpu_clear),
    .tok_in(tok_in), .tok_err(tok_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
    .ack_rx(ack_rx), .hs_timeout(hs_timeout),
    .nak_req(nak_req), .force_bs_err(force_bs_err), .ep_irq(ep_irq),
    .ep_enabled(ep_enabled), .byte_count(byte_count),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_raddr(mem_raddr)
  );

  txbuf_mem #(.DEPTH(DEPTH), .W(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .raddr(mem_raddr), .rdata(tx_data)
  );
endmodule

// File: rtl/usb_in_txbuf_chk.sv
module usb_in_txbuf_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          cpu_arm,
  input logic          cpu_clear,
  input logic          tok_in,
  input logic          tok_err,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          ack_rx,
  input logic          hs_timeout,
  input logic          nak_req,
  input logic          force_bs_err,
  input logic          ep_irq,
  input logic          ep_enabled,
  input logic [CW-1:0] byte_count
);
  assert_count_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_count <= CW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !cpu_clear && !ack_rx) |=> byte_count == $past(byte_count));

  assert_arm_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_arm && !cpu_clear && !tx_valid && !force_bs_err && !ack_rx) |=> ep_enabled);

  assert_bad_token_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && tok_err && !tx_valid && !cpu_clear && !cpu_arm && !ack_rx && !wr_valid)
      |=> (!tx_valid && !nak_req && $stable(byte_count) && $stable(ep_enabled)));

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !cpu_clear) |=> (tx_valid && $stable(tx_data)));

  assert_irq_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |-> (byte_count == '0 && !ep_enabled));

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |=> !ep_irq);

  assert_timeout_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_timeout && ep_enabled && !ack_rx && !cpu_clear)
      |=> (ep_enabled && !ep_irq && $stable(byte_count)));

  assert_force_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    force_bs_err |-> (!tx_valid && !ep_enabled));

  assert_clear_force_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clear && tx_valid) |=> force_bs_err);

  assert_nak_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nak_req |-> !tx_valid);
endmodule

bind usb_in_txbuf usb_in_txbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .cpu_arm(cpu_arm), .cpu_clear(cpu_clear), .tok_in(tok_in), .tok_err(tok_err),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .ack_rx(ack_rx), .hs_timeout(hs_timeout), .nak_req(nak_req),
  .force_bs_err(force_bs_err), .ep_irq(ep_irq), .ep_enabled(ep_enabled),
  .byte_count(byte_count)
);

// File: tb/usb_in_txbuf_test.sv
`timescale 1ns/1ps
module usb_in_txbuf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cfg_size = 7'd4;
  logic       wr_valid = 1'b0, cpu_arm = 1'b0, cpu_clear = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tok_in = 1'b0, tok_err = 1'b0, tx_ready = 1'b0;
  logic       ack_rx = 1'b0, hs_timeout = 1'b0;
  logic       wr_ready, tx_valid, tx_last, nak_req, force_bs_err, ep_irq, ep_enabled;
  logic [7:0] tx_data;
  logic [6:0] byte_count;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  usb_in_txbuf uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 16 + i * 7 + 1);
  endfunction

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr_byte(input logic [7:0] b);
    wr_valid = 1'b1; wr_data = b; cyc(); wr_valid = 1'b0;
  endtask

  task automatic pulse_tok(input logic err);
    tok_in = 1'b1; tok_err = err; cyc(); tok_in = 1'b0; tok_err = 1'b0;
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) wr_byte(pat(seed, i));
  endtask

  task automatic arm();
    cpu_arm = 1'b1; cyc(); cpu_arm = 1'b0;
  endtask

  task automatic drain(input int n, input int seed, input string req);
    for (int i = 0; i < n; i++) begin
      check({req, " valid"}, tx_valid, 1);
      check({req, " data"}, tx_data, pat(seed, i));
      check({req, " last"}, tx_last, (i == n - 1));
      tx_ready = 1'b1; cyc(); tx_ready = 1'b0;
    end
    check({req, " valid after end"}, tx_valid, 0);
  endtask

  task automatic t_reset_R1();
    check("R1 count", byte_count, 0);
    check("R1 enabled", ep_enabled, 0);
    check("R1 wr_ready", wr_ready, 1);
    check("R1 outs", {tx_valid, nak_req, ep_irq, force_bs_err}, 0);
  endtask

  task automatic t_fill_R2_R3();
    fill(4, 1);
    check("R2 count", byte_count, 4);
    check("R3 ready low at size", wr_ready, 0);
    wr_byte(8'hEE); cyc();
    check("R3 refused write", byte_count, 4);
  endtask

  task automatic t_nak_R6();
    pulse_tok(1'b0);
    check("R6 nak pulse", nak_req, 1);
    check("R6 no data", tx_valid, 0);
    cyc();
    check("R6 nak one cycle", nak_req, 0);
  endtask

  task automatic t_arm_err_R4_R5();
    arm();
    check("R4 enabled", ep_enabled, 1);
    check("R3 ready low armed", wr_ready, 0);
    pulse_tok(1'b1);
    check("R5 no data", tx_valid, 0);
    check("R5 no nak", nak_req, 0);
    cyc();
    check("R5 count kept", byte_count, 4);
    check("R5 still idle", tx_valid, 0);
  endtask

  task automatic t_send_timeout_R7_R9();
    pulse_tok(1'b0);
    check("R7 first byte", tx_data, pat(1, 0));
    cyc(); cyc();
    check("R7 held valid", tx_valid, 1);
    check("R7 held data", tx_data, pat(1, 0));
    drain(4, 1, "R7");
    hs_timeout = 1'b1; cyc(); hs_timeout = 1'b0;
    check("R9 enabled kept", ep_enabled, 1);
    check("R9 count kept", byte_count, 4);
    check("R9 no irq", ep_irq, 0);
    cyc();
    check("R9 no irq later", ep_irq, 0);
    pulse_tok(1'b0);
    drain(4, 1, "R9 replay");
  endtask

  task automatic t_ack_R8();
    ack_rx = 1'b1; cyc(); ack_rx = 1'b0;
    check("R8 irq", ep_irq, 1);
    check("R8 count", byte_count, 0);
    check("R8 disarmed", ep_enabled, 0);
    cyc();
    check("R8 irq one cycle", ep_irq, 0);
  endtask

  task automatic t_clear_R10();
    fill(3, 2); arm(); pulse_tok(1'b0);
    tx_ready = 1'b1; cyc(); tx_ready = 1'b0;
    cpu_clear = 1'b1; cyc(); cpu_clear = 1'b0;
    check("R10 force", force_bs_err, 1);
    check("R10 no valid", tx_valid, 0);
    check("R10 count", byte_count, 0);
    check("R10 disarmed", ep_enabled, 0);
    cyc(); cyc();
    check("R10 force held", force_bs_err, 1);
    hs_timeout = 1'b1; cyc(); hs_timeout = 1'b0;
    check("R10 force ends", force_bs_err, 0);
    check("R10 no irq", ep_irq, 0);
  endtask

  task automatic t_zlp_R11();
    arm(); pulse_tok(1'b0);
    check("R11 no byte", tx_valid, 0);
    check("R11 no nak", nak_req, 0);
    cyc();
    check("R11 still no byte", tx_valid, 0);
    ack_rx = 1'b1; cyc(); ack_rx = 1'b0;
    check("R11 irq", ep_irq, 1);
    check("R11 disarmed", ep_enabled, 0);
  endtask

  task automatic t_full_R3();
    cfg_size = 7'd64; cyc();
    fill(64, 3);
    check("R2 full count", byte_count, 64);
    check("R3 ready low full", wr_ready, 0);
    wr_byte(8'h55); cyc();
    check("R3 refused full", byte_count, 64);
    arm(); pulse_tok(1'b0);
    drain(64, 3, "R7 long");
    ack_rx = 1'b1; cyc(); ack_rx = 1'b0;
    check("R8 long irq", ep_irq, 1);
  endtask

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(); cyc();
    t_reset_R1();
    rst_n = 1'b1; cyc();
    t_reset_R1();
    t_fill_R2_R3();
    t_nak_R6();
    t_arm_err_R4_R5();
    t_send_timeout_R7_R9();
    t_ack_R8();
    t_clear_R10();
    t_zlp_R11();
    t_full_R3();
    cyc();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule